// File: doc/BRIEF.md
# Programmable Clock Divider with Output Phase Select

The block counts input clock cycles and produces a divided clock enable. The divide ratio is an integer from 1 to 8. A second output is a strobe that recurs at the same divided rate. Its position inside each divided period is set in whole input-clock cycles. Software-style configuration arrives through a simple write port: a write enable together with a ratio field and a phase field, which land in two configuration registers that can be read back.

The undelayed divider enable is the timing reference for internal sampling, and the phase setting never touches it. A phase write only moves where the output strobe falls inside the period. A ratio write is held pending until the counter wraps, so the running period is always finished at its old length and no shortened period appears.

Top module: `clk_div_phase`

## Requirements
- R1: The ratio field r (3 bits) selects division by r+1; with a stable ratio, `div_tick_o` is high for exactly one cycle in every r+1 cycles (counter position 0).
- R2: `out_stb_o` is high in the cycle that lies (phase mod (r+1)) cycles after each `div_tick_o` cycle, and in no other cycle of that period.
- R3: A phase value equal to or larger than r+1 acts as phase mod (r+1); for example, phase 6 at ratio 2 puts the strobe on the tick cycle, and phase 5 at ratio 2 puts it two cycles after the tick.
- R4: A ratio write is applied at the first counter wrap on a clock edge after the write's edge; the period that is running finishes at its old length.
- R5: A phase write never changes the timing of `div_tick_o`; the counter advances by one each cycle until it wraps.
- R6: With the active ratio at 0 (divide by 1), `div_tick_o` and `out_stb_o` are both high in every cycle, whatever the phase field holds.
- R7: While `rst_ni` is low, both configuration registers and the counter are 0. In the first cycle after release, `div_tick_o` and `out_stb_o` are both high.
- R8: `ratio_q_o` and `phase_q_o` show the value of the last write from the clock edge that stores it, even while that ratio is still pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_ratio_i | input | 3 | Ratio field to write (divide by value+1) |
| cfg_phase_i | input | 3 | Phase field to write (strobe delay in input cycles) |
| ratio_q_o | output | 3 | Stored ratio register |
| phase_q_o | output | 3 | Stored phase register |
| div_tick_o | output | 1 | Undelayed divided enable, one cycle per period |
| out_stb_o | output | 1 | Phase-selected output strobe, one cycle per period |

## Verification
If the counter holds a wrong value, the tick lands in the wrong place. This shows at `div_tick_o` within one divided period, which is at most eight cycles. If the active ratio is wrong, whether it was loaded too early or never loaded, the spacing between ticks changes at the first wrap after the write. A wrong phase reduction moves `out_stb_o` away from the offset after the tick that the bench predicts, and this shows in the next period. Because the bench compares every output in every cycle, each of these faults is caught within one period of where it first appears.

// File: rtl/clk_div_phase_pkg.sv
package clk_div_phase_pkg;
  localparam int unsigned RATIO_W_DEF = 3;
  localparam int unsigned PHASE_W_DEF = 3;
endpackage

// File: rtl/cdps_cfg_regs.sv
module cdps_cfg_regs #(
  parameter int unsigned RATIO_W = 3,
  parameter int unsigned PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [RATIO_W-1:0] ratio_wr_i,
  input  logic [PHASE_W-1:0] phase_wr_i,
  input  logic               wrap_i,
  output logic [RATIO_W-1:0] ratio_pend_o,
  output logic [RATIO_W-1:0] ratio_act_o,
  output logic [PHASE_W-1:0] phase_o
);
  logic [RATIO_W-1:0] pend_q, act_q;
  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      act_q   <= '0;
      phase_q <= '0;
    end else begin
      if (we_i) begin
        pend_q  <= ratio_wr_i;
        phase_q <= phase_wr_i;
      end
      // active ratio moves only at a wrap; uses value stored before this edge
      if (wrap_i) act_q <= pend_q;
    end
  end

  assign ratio_pend_o = pend_q;
  assign ratio_act_o  = act_q;
  assign phase_o      = phase_q;
endmodule

// File: rtl/cdps_counter.sv
module cdps_counter #(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_act_i,
  output logic [RATIO_W-1:0] cnt_o,
  output logic               wrap_o
);
  logic [RATIO_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == ratio_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cdps_phase_sel.sv
module cdps_phase_sel #(
  parameter int unsigned RATIO_W = 3,
  parameter int unsigned PHASE_W = 3
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [RATIO_W-1:0] ratio_act_i,
  output logic [RATIO_W-1:0] phase_eff_o
);
  localparam int unsigned CW   = ((PHASE_W > RATIO_W) ? PHASE_W : RATIO_W) + 1;
  localparam int unsigned ITER = 1 << PHASE_W;

  logic [CW-1:0] rem, den;

  // phase mod (ratio+1) by bounded repeated subtraction
  always_comb begin
    den = CW'(ratio_act_i) + CW'(1);
    rem = CW'(phase_i);
    for (int i = 0; i < ITER; i++) begin
      if (rem >= den) rem = rem - den;
    end
    phase_eff_o = rem[RATIO_W-1:0];
  end
endmodule

// File: rtl/clk_div_phase.sv
module clk_div_phase
  import clk_div_phase_pkg::*;
#(
  parameter int unsigned RATIO_W = RATIO_W_DEF,
  parameter int unsigned PHASE_W = PHASE_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic [PHASE_W-1:0] cfg_phase_i,
  output logic [RATIO_W-1:0] ratio_q_o,
  output logic [PHASE_W-1:0] phase_q_o,
  output logic               div_tick_o,
  output logic               out_stb_o
);
  logic [RATIO_W-1:0] ratio_act_q;
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] phase_eff;
  logic               wrap;

  cdps_cfg_regs #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .ratio_wr_i  (cfg_ratio_i),
    .phase_wr_i  (cfg_phase_i),
    .wrap_i      (wrap),
    .ratio_pend_o(ratio_q_o),
    .ratio_act_o (ratio_act_q),
    .phase_o     (phase_q_o)
  );

  cdps_counter #(.RATIO_W(RATIO_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ratio_act_i(ratio_act_q),
    .cnt_o      (cnt_q),
    .wrap_o     (wrap)
  );

  cdps_phase_sel #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_phase (
    .phase_i    (phase_q_o),
    .ratio_act_i(ratio_act_q),
    .phase_eff_o(phase_eff)
  );

  assign div_tick_o = (cnt_q == '0);
  assign out_stb_o  = (cnt_q == phase_eff);
endmodule

// File: rtl/clk_div_phase_chk.sv
module clk_div_phase_chk #(
  parameter int unsigned RATIO_W = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               div_tick_i,
  input logic               out_stb_i,
  input logic [RATIO_W-1:0] cnt_i,
  input logic [RATIO_W-1:0] act_i
);
  localparam int unsigned MAXDIV = 1 << RATIO_W;

  logic [RATIO_W:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= '0;
    else if (div_tick_i)                  gap_q <= (RATIO_W+1)'(1);
    else if (gap_q != {(RATIO_W+1){1'b1}}) gap_q <= gap_q + 1'b1;
  end

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= act_i);

  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_tick_i |-> (int'(gap_q) <= MAXDIV - 1));

  a_r4_ratio_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_i) |-> div_tick_i);

  a_r5_count_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_i) != $past(act_i)) |-> (cnt_i == RATIO_W'($past(cnt_i) + 1'b1)));

  a_r6_div1_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |-> (div_tick_i && out_stb_i));
endmodule

bind clk_div_phase clk_div_phase_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .div_tick_i(div_tick_o),
  .out_stb_i (out_stb_o),
  .cnt_i     (cnt_q),
  .act_i     (ratio_act_q)
);

// File: tb/clk_div_phase_test.sv
module clk_div_phase_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_ratio_i = '0;
  logic [2:0] cfg_phase_i = '0;
  logic [2:0] ratio_q_o, phase_q_o;
  logic       div_tick_o, out_stb_o;

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R7";
  int m_cnt, m_act, m_pend, m_ph;

  always #2 clk_i = ~clk_i;

  clk_div_phase uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
    .cfg_ratio_i(cfg_ratio_i), .cfg_phase_i(cfg_phase_i),
    .ratio_q_o(ratio_q_o), .phase_q_o(phase_q_o),
    .div_tick_o(div_tick_o), .out_stb_o(out_stb_o)
  );

  function automatic bit exp_tick();
    return m_cnt == 0;
  endfunction

  function automatic bit exp_stb();
    return m_cnt == (m_ph % (m_act + 1));
  endfunction

  task automatic chk(input string t, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk(tag, "div_tick", int'(div_tick_o), int'(exp_tick()));
    chk(tag, "out_stb", int'(out_stb_o), int'(exp_stb()));
    chk("R8", "ratio_q", int'(ratio_q_o), m_pend);
    chk("R8", "phase_q", int'(phase_q_o), m_ph);
  endtask

  task automatic model_adv(input bit we, input int r, input int p);
    if (m_cnt == m_act) begin
      m_cnt = 0;
      m_act = m_pend;
    end else m_cnt++;
    if (we) begin
      m_pend = r;
      m_ph   = p;
    end
  endtask

  task automatic step(input bit we, input int r, input int p);
    @(negedge clk_i);
    check_all();
    cfg_we_i    = we;
    cfg_ratio_i = 3'(r);
    cfg_phase_i = 3'(p);
    model_adv(we, r, p);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_we_i = 1'b0;
    m_cnt = 0; m_act = 0; m_pend = 0; m_ph = 0;
    @(negedge clk_i);
    tag = "R7";
    check_all();
    rst_ni = 1'b1;
    model_adv(0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    idle(3);
    // divide by 8, strobe on tick
    tag = "R1"; step(1, 7, 0); idle(24);
    // divide by 6, strobe 2 after tick
    tag = "R2"; step(1, 5, 2); idle(30);
    // phase wraps modulo ratio+1
    tag = "R3"; step(1, 2, 6); idle(15);
    step(1, 2, 5); idle(15);
    step(1, 4, 7); idle(15);
    // divide by 1 ignores phase
    tag = "R6"; step(1, 0, 7); idle(12);
    step(1, 0, 3); idle(6);
    // phase writes mid-period leave tick timing alone
    tag = "R5"; step(1, 7, 1); idle(10);
    for (int i = 0; i < 12; i++) begin
      step(1, 7, (i * 3) % 8);
      idle(2);
    end
    // ratio change mid-period waits for the wrap
    tag = "R4"; step(1, 3, 0); idle(9);
    step(0, 0, 0); step(1, 6, 1); idle(20);
    step(1, 1, 0); idle(3); step(1, 7, 2); idle(20);
    // random mix
    tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) step(1, $urandom_range(0, 7), $urandom_range(0, 7));
      else step(0, 0, 0);
    end
    // reset in mid-run after non-default config
    step(1, 5, 4); idle(7);
    do_reset();
    tag = "R7"; idle(4);
    step(1, 3, 2); idle(12);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule